// File: doc/BRIEF.md
# Boot Primary Processor Selector

This block picks which of up to four processor modules takes the boot role after power-up diagnostics have finished. Each slot reports whether a module is fitted, whether that module passed its self-test, and whether it has an entry in its error log. A fitted module that failed a test or has a logged error is screened out. The lowest-numbered module that survives the screen becomes the primary. If no module survives, slot 0 is named primary anyway, so that the machine can still try to reach a diagnosable state.

Besides the primary index, the block produces two more results. The first is a per-slot enable mask, which keeps faulty secondaries hidden from later software. The second is a single fault flag for the operator panel. The inputs are sampled once, on the first start strobe after reset. The results then stay frozen until the next reset, and a done flag marks them valid.

Top module: `boot_primary_select`

## Requirements
- R1: While reset is high and after it falls, before any start strobe, `done_o`, `fault_o`, `primary_o` and `enable_o` are all zero.
- R2: Slot i is eligible when `present_i[i]`=1, `pass_i[i]`=1 and `errlog_i[i]`=0. Slot i is failed when it is present and either `pass_i[i]`=0 or `errlog_i[i]`=1. An absent slot is neither eligible nor failed.
- R3: `primary_o` is the binary index of the lowest-numbered eligible slot (bit 0 of each input mask is CPU0).
- R4: When no slot is eligible, `primary_o` is 0.
- R5: `fault_o` is 1 exactly when at least one slot is failed. Absent slots never raise it.
- R6: `enable_o` bit i is 1 for every eligible slot and for the chosen primary, and 0 for every other slot. This means a forced CPU0 is enabled even when it failed or is absent.
- R7: The inputs are sampled at the rising clock edge where `start_i`=1 and `done_o`=0. The results and `done_o`=1 appear from that edge on.
- R8: After `done_o` is 1, further strobes and input changes have no effect on any output until reset.
- R9: A synchronous reset clears the held result, and a later strobe performs a fresh selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe: diagnostics complete, sample the inputs |
| present_i | input | 4 | Module fitted, one bit per slot |
| pass_i | input | 4 | Self-test passed, one bit per slot |
| errlog_i | input | 4 | Error recorded in the module's log, one bit per slot |
| primary_o | output | 2 | Index of the boot processor |
| enable_o | output | 4 | Per-slot processor enable |
| fault_o | output | 1 | Operator-panel fault indication |
| done_o | output | 1 | Selection made, outputs valid and held |

## Verification
All results come out of one register stage. They are therefore due one clock edge after the strobe edge: the strobe is driven on a falling edge, it is captured on the next rising edge, and the outputs are read on the falling edge after that. The driver queues the expected primary, mask and fault as it raises the strobe. The monitor pops the queued entry on the falling edge where `done_o` is first seen high, and compares it there. The hold checks change every input and strobe again after completion, wait several edges, and then compare the outputs with the values captured earlier.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    // Number of processor slots and derived index width
    localparam int NUM_CPU = 4;
    localparam int IDX_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    typedef logic [NUM_CPU-1:0] cpu_mask_t;
    typedef logic [IDX_W-1:0]   cpu_idx_t;

    // Slot reported by the picker when nothing is eligible
    localparam cpu_idx_t FALLBACK_IDX = '0;

    // Everything the block decides, kept together so it is captured at once
    typedef struct packed {
        cpu_idx_t  primary;
        cpu_mask_t enable;
        logic      fault;
    } sel_result_t;

    // Per-slot screening outcome
    typedef struct packed {
        cpu_mask_t eligible;
        cpu_mask_t failed;
    } screen_t;

    function automatic cpu_mask_t idx_to_onehot(input cpu_idx_t idx);
        cpu_mask_t m;
        m = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (cpu_idx_t'(i) == idx) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/bsel_screen.sv
module bsel_screen
    import boot_sel_pkg::*;
(
    input  cpu_mask_t present,
    input  cpu_mask_t pass,
    input  cpu_mask_t errlog,
    output screen_t   screen
);

    // One identical screen cell per slot
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
        logic healthy;
        assign healthy               = pass[g] & ~errlog[g];
        assign screen.eligible[g]    = present[g] & healthy;
        assign screen.failed[g]      = present[g] & ~healthy;
    end

endmodule

// File: rtl/bsel_pick.sv
module bsel_pick
    import boot_sel_pkg::*;
(
    input  cpu_mask_t eligible,
    output cpu_idx_t  idx,
    output logic      found
);

    // seen[i] is set when any slot below i is eligible
    cpu_mask_t seen;
    cpu_mask_t first;

    assign seen[0] = 1'b0;
    for (genvar g = 1; g < NUM_CPU; g++) begin : g_chain
        assign seen[g] = seen[g-1] | eligible[g-1];
    end

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_first
        assign first[g] = eligible[g] & ~seen[g];
    end

    // Encode the single set bit of first (at most one)
    always_comb begin
        idx = FALLBACK_IDX;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (first[i]) idx = cpu_idx_t'(i);
        end
    end

    assign found = |eligible;

endmodule

// File: rtl/bsel_hold.sv
module bsel_hold
    import boot_sel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  sel_result_t next_res,
    output sel_result_t res,
    output logic        done
);

    sel_result_t res_q;
    logic        done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else if (start && !done_q) begin
            res_q  <= next_res;
            done_q <= 1'b1;
        end
    end

    assign res  = res_q;
    assign done = done_q;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> (done_q && $stable(res_q)));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(start));

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !done_q) |=> (res_q == $past(next_res)));

endmodule

// File: rtl/boot_primary_select.sv
module boot_primary_select
    import boot_sel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [NUM_CPU-1:0]   present_i,
    input  logic [NUM_CPU-1:0]   pass_i,
    input  logic [NUM_CPU-1:0]   errlog_i,
    output logic [IDX_W-1:0]     primary_o,
    output logic [NUM_CPU-1:0]   enable_o,
    output logic                 fault_o,
    output logic                 done_o
);

    screen_t     scr;
    cpu_idx_t    pick_idx;
    logic        pick_found;
    sel_result_t next_res;
    sel_result_t held;

    bsel_screen u_screen (
        .present (present_i),
        .pass    (pass_i),
        .errlog  (errlog_i),
        .screen  (scr)
    );

    bsel_pick u_pick (
        .eligible (scr.eligible),
        .idx      (pick_idx),
        .found    (pick_found)
    );

    always_comb begin
        next_res.primary = pick_idx;
        next_res.enable  = scr.eligible | idx_to_onehot(pick_idx);
        next_res.fault   = |scr.failed;
    end

    bsel_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .next_res (next_res),
        .res      (held),
        .done     (done_o)
    );

    assign primary_o = held.primary;
    assign enable_o  = held.enable;
    assign fault_o   = held.fault;

    // R2
    screen_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (scr.eligible & scr.failed) == '0);

    // R4
    fallback_chk: assert property (@(posedge clk) disable iff (rst)
        !pick_found |-> (pick_idx == FALLBACK_IDX));

    // R3
    pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pick_found |-> scr.eligible[pick_idx]);

    // R6
    primary_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> enable_o[primary_o]);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (enable_o == '0 && !fault_o && primary_o == '0));

endmodule

// File: tb/test_boot_primary_select.sv
module test_boot_primary_select;
    import boot_sel_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    cpu_mask_t present = '0;
    cpu_mask_t pass = '0;
    cpu_mask_t errlog = '0;
    cpu_idx_t  primary;
    cpu_mask_t enable;
    logic      fault;
    logic      done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    boot_primary_select i_boot_primary_select (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .present_i (present),
        .pass_i    (pass),
        .errlog_i  (errlog),
        .primary_o (primary),
        .enable_o  (enable),
        .fault_o   (fault),
        .done_o    (done)
    );

    typedef struct {
        cpu_idx_t  p;
        cpu_mask_t e;
        logic      f;
        string     tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference model written from the requirements
    function automatic exp_t model(cpu_mask_t pr, cpu_mask_t ps, cpu_mask_t el, string tag);
        exp_t r;
        cpu_mask_t elig;
        bit got;
        elig = '0; r.f = 1'b0; got = 0; r.p = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (pr[i] && ps[i] && !el[i]) elig[i] = 1'b1;        // R2
            if (pr[i] && (!ps[i] || el[i])) r.f = 1'b1;          // R5
        end
        for (int i = 0; i < NUM_CPU; i++) begin
            if (elig[i] && !got) begin r.p = cpu_idx_t'(i); got = 1; end  // R3
        end
        if (!got) r.p = '0;                                      // R4
        r.e = elig;
        r.e[r.p] = 1'b1;                                         // R6
        r.tag = tag;
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected entry on the first falling edge with done high
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (done && !prev_done) begin
            if (exp_q.size() == 0) begin
                check(0, "R7", "unexpected result", 1, 0);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(primary == x.p, x.tag, "primary", int'(primary), int'(x.p));
                check(enable  == x.e, x.tag, "enable",  int'(enable),  int'(x.e));
                check(fault   == x.f, x.tag, "fault",   int'(fault),   int'(x.f));
            end
        end
        prev_done = done;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 0 && enable == '0 && !fault && primary == '0, "R1", "in reset",
              {done, fault, primary, enable}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 0 && enable == '0 && !fault && primary == '0, "R1", "idle after reset",
              {done, fault, primary, enable}, 0);
    endtask

    // Driver: sets inputs, strobes once, queues the expectation
    task automatic apply(cpu_mask_t pr, cpu_mask_t ps, cpu_mask_t el, string tag);
        present = pr; pass = ps; errlog = el;
        exp_q.push_back(model(pr, ps, el, tag));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1, "R7", "done one edge after strobe", int'(done), 1);
        @(negedge clk);
    endtask

    task automatic run_case(cpu_mask_t pr, cpu_mask_t ps, cpu_mask_t el, string tag);
        do_reset();
        apply(pr, ps, el, tag);
    endtask

    initial begin
        // R1 / R7: no strobe means no result
        do_reset();
        repeat (3) @(negedge clk);
        check(done == 0, "R7", "no strobe stays idle", int'(done), 0);

        run_case(4'b1111, 4'b1111, 4'b0000, "R3");  // all good -> CPU0
        run_case(4'b1111, 4'b1110, 4'b0000, "R3");  // CPU0 fails -> CPU1
        run_case(4'b1111, 4'b1000, 4'b0000, "R3");  // CPU0..2 fail -> CPU3
        run_case(4'b1111, 4'b0000, 4'b0000, "R4");  // all fail -> forced CPU0
        run_case(4'b1111, 4'b1111, 4'b0011, "R2");  // logged errors exclude
        run_case(4'b1111, 4'b1111, 4'b0010, "R6");  // failed secondary disabled
        run_case(4'b1110, 4'b1110, 4'b0000, "R5");  // absent CPU0, no fault
        run_case(4'b0000, 4'b0000, 4'b0000, "R4");  // nothing fitted
        run_case(4'b1011, 4'b1101, 4'b0000, "R6");  // absent + failed mix
        run_case(4'b0100, 4'b0000, 4'b0000, "R5");  // lone failed CPU2

        // R8: later strobe and input changes ignored
        run_case(4'b1111, 4'b1110, 4'b0000, "R8");
        present = 4'b1111; pass = 4'b1111; errlog = 4'b0000;
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(primary == 2'd1, "R8", "primary held", int'(primary), 1);
        check(enable == 4'b1110, "R8", "enable held", int'(enable), 4'he);
        check(fault == 1'b1 && done == 1'b1, "R8", "fault/done held", {fault, done}, 3);

        // R9: reset then a fresh selection
        run_case(4'b1111, 4'b1111, 4'b0000, "R9");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R7", "all results seen", exp_q.size(), 0);
        finished = 1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule